// File: doc/BRIEF.md
# Segment Register Loader with Descriptor Fetch

This block takes a 16-bit selector written into one of a small bank of segment registers and fills that register's hidden cache. With protection off, the hidden base is simply the selector shifted left by four, and no memory is touched. With protection on, the selector is split into an index, a table-select bit and a requested privilege level. The block adds the index times eight to the base of the chosen descriptor table. It then reads the 8-byte descriptor as two 32-bit words over a plain read interface. From those words it gathers the base, the limit (scaled when the granularity bit is set) and the privilege level into the hidden cache.

General loads arrive on a move-style port that names the target register. Register 0 is the code register, and it cannot be written there. It is written only through a separate control-transfer port, which wins when both ports request in the same cycle. Register 1 is the stack register. A protected-mode load of a null selector into the code or stack register raises a one-cycle fault and leaves the cache alone. Once a load has completed, the cached fields can be read combinationally through a read-select port, and no further table reads take place.

Top module: `seg_load_unit`

## Requirements
- R1: A selector carries its index in bits 15:3, the table-select bit in bit 2 (0 = global table base `gdt_base`, 1 = local table base `ldt_base`) and the requested privilege in bits 1:0. The first descriptor read goes to table base + index*8.
- R2: A protected-mode load issues exactly two reads, the low word at the entry address and the high word at entry+4. `mem_addr` holds steady while `mem_rd` waits for `mem_rvalid`.
- R3: The cached base is {high[31:24], high[7:0], low[31:16]}.
- R4: The raw 20-bit limit is {high[19:16], low[15:0]}. When high[23] is 1, the cached limit is {raw, 12'hFFF}; otherwise it is the zero-extended raw value.
- R5: The cached privilege level is high[14:13]. The cached selector is the loaded selector.
- R6: With `pm_en` low, a load sets the base to selector*16 and the selector field, issues no read, and raises `done` in the cycle after acceptance.
- R7: A move-port load naming register 0 is ignored: no `done`, no `fault`, and the cache is unchanged.
- R8: The control-transfer port loads register 0.
- R9: With `pm_en` high, a selector with index 0 and table bit 0 loaded into register 0 or 1 pulses `fault` for one cycle in the cycle after acceptance. It issues no read and does not pulse `done`. The cache is unchanged.
- R10: Load requests that arrive while `busy` is high are ignored.
- R11: `done` is a single-cycle pulse. When it is high, `busy` is low and the cache already holds the new values.
- R12: Reading cached fields through `rd_seg` causes no memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_en | input | 1 | Protection enabled (descriptor fetch mode) |
| gdt_base | input | ADDR_W | Global descriptor table base |
| ldt_base | input | ADDR_W | Local descriptor table base |
| ld_req | input | 1 | Move-style load request |
| ld_seg | input | $clog2(NUM_SEG) | Target register of move-style load |
| ld_sel | input | 16 | Selector for move-style load |
| xfer_req | input | 1 | Control-transfer load of register 0 |
| xfer_sel | input | 16 | Selector for control-transfer load |
| busy | output | 1 | Descriptor fetch in progress |
| done | output | 1 | One-cycle pulse after the cache update |
| fault | output | 1 | One-cycle null-selector fault pulse |
| mem_rd | output | 1 | Read request, held until `mem_rvalid` |
| mem_addr | output | ADDR_W | Read address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data word |
| rd_seg | input | $clog2(NUM_SEG) | Cache read select |
| rd_sel | output | 16 | Cached selector |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 32 | Cached, scaled limit |
| rd_dpl | output | 2 | Cached privilege level |

## Verification
The assertions assume that `mem_rvalid` is pulsed only while `mem_rd` is high and only for one cycle per request. They also assume that `pm_en` and the table bases stay constant while `busy` is high. The bench's memory model answers only after it has seen `mem_rd`, and drops `mem_rvalid` after each single-cycle response. Mode and table bases change only between loads, never while a fetch is outstanding. Random selectors that would form a null selector for registers 0 or 1 are steered away, so that those cases are exercised only by the directed fault tests.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEL_W = 16;
  localparam int CODE_ID = 0;
  localparam int STACK_ID = 1;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [31:0]      base;
    logic [31:0]      limit;
    logic [1:0]       dpl;
  } seg_cache_t;

  typedef enum logic [1:0] {F_IDLE, F_RD0, F_RD1, F_FIN} fetch_st_t;

  // Gather scattered descriptor fields from the two fetched words.
  function automatic seg_cache_t unpack_desc(input logic [SEL_W-1:0] sel,
                                             input logic [31:0] lo,
                                             input logic [31:0] hi);
    seg_cache_t c;
    logic [19:0] raw;
    raw     = {hi[19:16], lo[15:0]};
    c.sel   = sel;
    c.base  = {hi[31:24], hi[7:0], lo[31:16]};
    c.limit = hi[23] ? {raw, 12'hFFF} : {12'h000, raw};
    c.dpl   = hi[14:13];
    return c;
  endfunction
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int ADDR_W = 32
) (
  input  logic [15:0]       sel,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] ldt_base,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              is_null
);
  logic [ADDR_W-1:0] tbl;
  always_comb begin
    tbl        = sel[2] ? ldt_base : gdt_base;
    entry_addr = tbl + ADDR_W'({sel[15:3], 3'b000});
    is_null    = (sel[15:3] == 13'd0) && !sel[2];
  end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] entry_addr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       word_lo,
  output logic [31:0]       word_hi,
  output logic              busy,
  output logic              fin
);
  fetch_st_t st;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      addr_q  <= '0;
      word_lo <= '0;
      word_hi <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          st     <= F_RD0;
          addr_q <= entry_addr;
        end
        F_RD0: if (mem_rvalid) begin
          word_lo <= mem_rdata;
          addr_q  <= addr_q + ADDR_W'(4);
          st      <= F_RD1;
        end
        F_RD1: if (mem_rvalid) begin
          word_hi <= mem_rdata;
          st      <= F_FIN;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign mem_rd   = (st == F_RD0) || (st == F_RD1);
  assign mem_addr = addr_q;
  assign busy     = (st != F_IDLE);
  assign fin      = (st == F_FIN);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_rvalid) |=> $stable(mem_addr)); // R2
  AST_FIN_RELEASES: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy); // R10
endmodule

// File: rtl/seg_hidden_bank.sv
module seg_hidden_bank
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 4,
  localparam int SEG_W = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_full,
  input  logic [SEG_W-1:0] wr_id,
  input  seg_cache_t       wr_ent,
  input  logic [SEG_W-1:0] rd_id,
  output seg_cache_t       rd_ent
);
  seg_cache_t ent_w [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_reg
    seg_cache_t ent_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_r <= '{sel: '0, base: '0, limit: 32'h0000_FFFF, dpl: 2'd0};
      end else if (wr_en && wr_id == SEG_W'(g)) begin
        if (wr_full) begin
          ent_r <= wr_ent;
        end else begin
          ent_r.sel  <= wr_ent.sel;
          ent_r.base <= wr_ent.base;
        end
      end
    end
    assign ent_w[g] = ent_r;
  end

  assign rd_ent = ent_w[rd_id];
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int ADDR_W  = 32,
  localparam int SEG_W  = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pm_en,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic              ld_req,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [15:0]       ld_sel,
  input  logic              xfer_req,
  input  logic [15:0]       xfer_sel,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic [SEG_W-1:0]  rd_seg,
  output logic [15:0]       rd_sel,
  output logic [31:0]       rd_base,
  output logic [31:0]       rd_limit,
  output logic [1:0]        rd_dpl
);
  logic              accept, null_sel, fault_cond, start_fetch, fin;
  logic [SEG_W-1:0]  tgt, tgt_q;
  logic [15:0]       sel_in, sel_q;
  logic [ADDR_W-1:0] entry_addr;
  logic [31:0]       word_lo, word_hi;
  logic              done_q, fault_q;
  logic              wr_en, wr_full;
  logic [SEG_W-1:0]  wr_id;
  seg_cache_t        wr_ent, rd_ent;

  // Control-transfer port has priority and always targets the code register.
  always_comb begin
    tgt    = xfer_req ? SEG_W'(CODE_ID) : ld_seg;
    sel_in = xfer_req ? xfer_sel : ld_sel;
    accept = !busy && (xfer_req || (ld_req && ld_seg != SEG_W'(CODE_ID)));
  end

  seg_sel_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(sel_in), .gdt_base(gdt_base), .ldt_base(ldt_base),
    .entry_addr(entry_addr), .is_null(null_sel)
  );

  assign fault_cond  = pm_en && null_sel &&
                       (tgt == SEG_W'(CODE_ID) || tgt == SEG_W'(STACK_ID));
  assign start_fetch = accept && pm_en && !fault_cond;

  seg_desc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst(rst), .start(start_fetch), .entry_addr(entry_addr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .word_lo(word_lo), .word_hi(word_hi),
    .busy(busy), .fin(fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      tgt_q   <= '0;
      sel_q   <= '0;
    end else begin
      done_q  <= fin || (accept && !pm_en);
      fault_q <= accept && fault_cond;
      if (accept) begin
        tgt_q <= tgt;
        sel_q <= sel_in;
      end
    end
  end

  // Write port: immediate real-mode write, or full write at fetch end.
  always_comb begin
    if (fin) begin
      wr_en   = 1'b1;
      wr_full = 1'b1;
      wr_id   = tgt_q;
      wr_ent  = unpack_desc(sel_q, word_lo, word_hi);
    end else begin
      wr_en   = accept && !pm_en;
      wr_full = 1'b0;
      wr_id   = tgt;
      wr_ent  = '{sel: sel_in, base: {12'h000, sel_in, 4'h0},
                  limit: '0, dpl: '0};
    end
  end

  seg_hidden_bank #(.NUM_SEG(NUM_SEG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_full(wr_full), .wr_id(wr_id),
    .wr_ent(wr_ent), .rd_id(rd_seg), .rd_ent(rd_ent)
  );

  assign done     = done_q;
  assign fault    = fault_q;
  assign rd_sel   = rd_ent.sel;
  assign rd_base  = rd_ent.base;
  assign rd_limit = rd_ent.limit;
  assign rd_dpl   = rd_ent.dpl;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fault && done)); // R9
  AST_CODE_MOVE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ld_req && !xfer_req && ld_seg == SEG_W'(CODE_ID) && !busy)
      |=> (!done && !fault)); // R7
  AST_READ_ONLY_PM: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> pm_en); // R6
endmodule

// File: tb/seg_load_unit_tb.sv
module seg_load_unit_tb;
  localparam int NS = 4;
  localparam int SW = 2;

  logic        clk = 0, rst = 1, pm_en = 0;
  logic [31:0] gdt_base = 32'h0010_0000, ldt_base = 32'h0020_8000;
  logic        ld_req = 0, xfer_req = 0;
  logic [SW-1:0] ld_seg = 0, rd_seg = 0;
  logic [15:0] ld_sel = 0, xfer_sel = 0;
  logic        busy, done, fault, mem_rd, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [15:0] rd_sel;
  logic [31:0] rd_base, rd_limit;
  logic [1:0]  rd_dpl;

  int checks = 0, errors = 0, nreads = 0, lat = 0;
  logic [31:0] alog [4];

  always #10 clk = ~clk;

  seg_load_unit #(.NUM_SEG(NS), .ADDR_W(32)) u_dut (
    .clk(clk), .rst(rst), .pm_en(pm_en), .gdt_base(gdt_base), .ldt_base(ldt_base),
    .ld_req(ld_req), .ld_seg(ld_seg), .ld_sel(ld_sel), .xfer_req(xfer_req),
    .xfer_sel(xfer_sel), .busy(busy), .done(done), .fault(fault),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rd_seg(rd_seg), .rd_sel(rd_sel), .rd_base(rd_base),
    .rd_limit(rd_limit), .rd_dpl(rd_dpl)
  );

  function automatic logic [31:0] mword(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] exp_entry(input logic [15:0] s);
    return (s[2] ? ldt_base : gdt_base) + {16'h0, s[15:3], 3'b000};
  endfunction

  // Memory model: one-cycle response after a random latency.
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid <= 0;
    end else if (mem_rd) begin
      if (lat == 0) begin
        mem_rvalid <= 1;
        mem_rdata  <= mword(mem_addr);
        if (nreads < 4) alog[nreads] = mem_addr;
        nreads = nreads + 1;
        lat = $urandom % 3;
      end else lat = lat - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd_cache(input int s);
    rd_seg = SW'(s);
    #1;
  endtask

  task automatic issue(input bit via_x, input int s, input logic [15:0] sel,
                       output bit got_done, output bit got_fault);
    @(negedge clk);
    nreads = 0;
    if (via_x) begin xfer_req = 1; xfer_sel = sel; end
    else begin ld_req = 1; ld_seg = SW'(s); ld_sel = sel; end
    @(negedge clk);
    xfer_req = 0; ld_req = 0;
    got_done = 0; got_fault = 0;
    for (int k = 0; k < 40; k++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    got_done = done; got_fault = fault;
    if (done) chk(!busy, "R11", "busy at done", 32'(busy), 0);
    @(negedge clk);
    chk(!done && !fault, "R11", "pulse width", {30'h0, done, fault}, 0);
  endtask

  initial begin
    bit d, f;
    logic [31:0] hi, lo, e;
    logic [15:0] sel, prev_sel;
    logic [31:0] prev_base, prev_lim;
    int s, r0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // Reset state
    chk(!busy && !done && !fault && !mem_rd, "R11", "reset outputs",
        {28'h0, busy, done, fault, mem_rd}, 0);
    rd_cache(1);
    chk(rd_base == 0 && rd_limit == 32'hFFFF, "R12", "reset cache", rd_limit, 32'hFFFF);

    // Real mode loads (R6, R8)
    for (int i = 0; i < 8; i++) begin
      s = i % NS; sel = 16'($urandom);
      issue(s == 0, s, sel, d, f);
      chk(d && !f, "R6", "real done", {30'h0, d, f}, 32'h2);
      chk(nreads == 0, "R6", "real reads", nreads, 0);
      rd_cache(s);
      chk(rd_base == {12'h0, sel, 4'h0}, s == 0 ? "R8" : "R6", "real base",
          rd_base, {12'h0, sel, 4'h0});
      chk(rd_sel == sel, "R6", "real sel", rd_sel, sel);
    end

    // Move-port load of code register ignored (R7)
    rd_cache(0); prev_sel = rd_sel; prev_base = rd_base;
    issue(0, 0, 16'h1234, d, f);
    chk(!d && !f, "R7", "no done/fault", {30'h0, d, f}, 0);
    rd_cache(0);
    chk(rd_sel == prev_sel && rd_base == prev_base, "R7", "code cache kept", rd_sel, prev_sel);

    // Protected mode random loads
    pm_en = 1;
    for (int i = 0; i < 40; i++) begin
      s = $urandom % NS; sel = 16'($urandom);
      if (s < 2 && sel[15:3] == 0 && !sel[2]) sel[3] = 1'b1;
      if (i == 3) gdt_base = 32'h0040_0010;
      if (i == 20) ldt_base = 32'h00A0_0000;
      issue(s == 0, s, sel, d, f);
      e = exp_entry(sel); lo = mword(e); hi = mword(e + 4);
      chk(d && !f, s == 0 ? "R8" : "R2", "pm done", {30'h0, d, f}, 32'h2);
      chk(nreads == 2, "R2", "read count", nreads, 2);
      chk(alog[0] == e, "R1", "entry addr", alog[0], e);
      chk(alog[1] == e + 4, "R2", "second addr", alog[1], e + 4);
      r0 = nreads;
      rd_cache(s);
      chk(rd_base == {hi[31:24], hi[7:0], lo[31:16]}, "R3", "base", rd_base,
          {hi[31:24], hi[7:0], lo[31:16]});
      chk(rd_limit == (hi[23] ? {hi[19:16], lo[15:0], 12'hFFF} : {12'h0, hi[19:16], lo[15:0]}),
          "R4", "limit", rd_limit,
          hi[23] ? {hi[19:16], lo[15:0], 12'hFFF} : {12'h0, hi[19:16], lo[15:0]});
      chk(rd_dpl == hi[14:13] && rd_sel == sel, "R5", "dpl/sel", {14'h0, rd_dpl, rd_sel},
          {14'h0, hi[14:13], sel});
      repeat (3) @(negedge clk);
      for (int q = 0; q < NS; q++) rd_cache(q);
      chk(nreads == r0, "R12", "no reads on cache use", nreads, r0);
    end

    // Null selector into code / stack registers (R9)
    for (int q = 0; q < 2; q++) begin
      rd_cache(q); prev_sel = rd_sel; prev_base = rd_base; prev_lim = rd_limit;
      issue(q == 0, q, 16'h0003, d, f);
      chk(f && !d, "R9", "fault pulse", {30'h0, d, f}, 1);
      chk(nreads == 0, "R9", "no reads", nreads, 0);
      rd_cache(q);
      chk(rd_sel == prev_sel && rd_base == prev_base && rd_limit == prev_lim,
          "R9", "cache kept", rd_base, prev_base);
    end

    // Requests during busy ignored (R10)
    rd_cache(3); prev_sel = rd_sel; prev_base = rd_base;
    @(negedge clk);
    nreads = 0;
    ld_req = 1; ld_seg = 2; ld_sel = 16'h0AB8;
    @(negedge clk);
    ld_seg = 3; ld_sel = 16'h0CC4;
    chk(busy == 1, "R10", "busy after start", 32'(busy), 1);
    repeat (2) @(negedge clk);
    ld_req = 0;
    for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    chk(done == 1, "R10", "first load done", 32'(done), 1);
    repeat (2) @(negedge clk);
    chk(nreads == 2, "R10", "reads", nreads, 2);
    rd_cache(3);
    chk(rd_sel == prev_sel && rd_base == prev_base, "R10", "seg3 kept", rd_sel, prev_sel);
    rd_cache(2);
    chk(rd_sel == 16'h0AB8, "R10", "seg2 loaded", rd_sel, 16'h0AB8);

    // Both ports at once: control-transfer wins (R8)
    @(negedge clk);
    nreads = 0;
    xfer_req = 1; xfer_sel = 16'h0010; ld_req = 1; ld_seg = 2; ld_sel = 16'h0018;
    @(negedge clk);
    xfer_req = 0; ld_req = 0;
    for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    rd_cache(0);
    chk(rd_sel == 16'h0010, "R8", "xfer priority", rd_sel, 16'h0010);
    rd_cache(2);
    chk(rd_sel == 16'h0AB8, "R8", "move port dropped", rd_sel, 16'h0AB8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule